// File: doc/BRIEF.md
# Instruction Fetch Decoupling Queue

This block sits between the final fetch stage and the decode stage of a scalar pipeline. Fetch hands it 32-bit words. Decode receives one instruction per cycle. Both sides use a valid/ready handshake. Decode also has a stall input that blocks consumption even when its ready is high.

The queue holds two fetch words. When decode stalls, fetch keeps writing until both entries are occupied. The backpressure therefore reaches fetch one or more cycles after the stall begins. A flush input, raised for a taken branch, empties the queue in one cycle.

The mode input selects how each word is issued. With `compact` low, every word is a single 32-bit instruction. With `compact` high, every word carries two 16-bit instructions. The block issues the lower halfword first and then the upper halfword. Compact mode adds one pipeline step between fetch and decode. The mode is expected to change only in a cycle where flush is also raised.

Top module: `ifetch_queue`

## Requirements
- R1: After synchronous active-high reset, `dec_valid` is 0 and `fetch_ready` is 1.
- R2: With `compact`=0, a word accepted into an empty queue at a clock edge is shown on `dec_instr` with `dec_valid`=1 right after that edge. Words leave in the order they were accepted.
- R3: With `compact`=1, each word yields two instructions. First comes bits [15:0] with `dec_upper`=0, then bits [31:16] with `dec_upper`=1. Each appears zero-extended in `dec_instr[15:0]`, with `dec_instr[31:16]`=0.
- R4: With `compact`=1, a word accepted into an empty queue is not shown in the cycle after the accepting edge. It is shown one cycle later.
- R5: The queue holds at most two words. `fetch_ready` is 0 only when two words are held and decode is not removing one in the same cycle.
- R6: An instruction is taken only when `dec_valid`, `dec_ready` are 1 and `dec_stall` is 0. While not taken, `dec_valid` stays 1 and `dec_instr` stays unchanged.
- R7: When a word is accepted and one is removed in the same cycle, the occupancy is unchanged. A full queue can accept a word in a cycle where it removes one.
- R8: With `compact`=1, a word is removed only when its upper half is taken. Taking the lower half of a word in a full queue leaves `fetch_ready` at 0.
- R9: Flush empties the queue and forgets a half-issued compact word, so `dec_valid` is 0 in the next cycle. A word offered together with flush is dropped.
- R10: With fetch always valid and decode always taking, after the first instruction `dec_valid` stays 1 every cycle, in both modes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| compact | input | 1 | 1: two 16-bit instructions per word; 0: one 32-bit instruction |
| flush | input | 1 | Empties the queue, priority over an incoming word |
| fetch_valid | input | 1 | Fetch offers a word |
| fetch_word | input | 32 | Fetched word |
| fetch_ready | output | 1 | Queue can accept a word this cycle |
| dec_ready | input | 1 | Decode can take an instruction |
| dec_stall | input | 1 | Decode stall, blocks consumption |
| dec_valid | output | 1 | An instruction is presented |
| dec_instr | output | 32 | Presented instruction, zero-extended in compact mode |
| dec_upper | output | 1 | 1 when the presented instruction is an upper halfword |

## Verification
The bench streams numbered words in both modes. It sweeps every pairing of fetch gaps (offer every 1, 2 or 3 cycles) with decode gaps (take every 1, 2 or 3 cycles), with periodic stalls added. This exercises the cases of an empty queue, a full queue, and simultaneous push and pop. In compact mode the halfwords carry consecutive numbers, so any swap of lower and upper halves, repeated halfword, or lost word shows up as a break in the count. The bench checks `fetch_ready` in every cycle against an occupancy it tracks itself. That separates the full-with-pop case from the full-without-pop case, including the case where a compact lower half is taken but the word is not yet removed. Directed sequences measure the one-cycle and two-cycle presentation latencies. They also cover flush with a pending word and flush in the middle of a compact word.

// File: rtl/ifq_pkg.sv
package ifq_pkg;

    typedef enum logic {
        ISSUE_WORD = 1'b0,
        ISSUE_HALF = 1'b1
    } issue_mode_e;

    typedef struct packed {
        logic lower_done;
        logic armed;
    } unpack_state_t;

    function automatic int ptr_w(input int depth);
        return (depth > 1) ? $clog2(depth) : 1;
    endfunction

    function automatic int cnt_w(input int depth);
        return $clog2(depth + 1);
    endfunction

endpackage

// File: rtl/ifq_store.sv
module ifq_store #(
    parameter int WORD_W = 32,
    parameter int DEPTH  = 2,
    localparam int CW    = ifq_pkg::cnt_w(DEPTH)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              flush,
    input  logic              push,
    input  logic [WORD_W-1:0] wr_word,
    input  logic              pop,
    output logic [WORD_W-1:0] head_word,
    output logic [CW-1:0]     fill
);
    localparam int PW = ifq_pkg::ptr_w(DEPTH);
    localparam logic [PW-1:0] LAST = PW'(DEPTH - 1);

    logic [PW-1:0]     wr_ptr;
    logic [PW-1:0]     rd_ptr;
    logic [WORD_W-1:0] slot_rd [DEPTH];

    function automatic logic [PW-1:0] bump(input logic [PW-1:0] p);
        return (p == LAST) ? '0 : p + PW'(1);
    endfunction

    generate
        for (genvar i = 0; i < DEPTH; i++) begin : g_slot
            logic [WORD_W-1:0] slot_q;
            always_ff @(posedge clk) begin
                if (push && wr_ptr == PW'(i)) begin
                    slot_q <= wr_word;
                end
            end
            assign slot_rd[i] = slot_q;
        end
    endgenerate

    assign head_word = slot_rd[rd_ptr];

    always_ff @(posedge clk) begin
        if (rst || flush) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            fill   <= '0;
        end else begin
            if (push) wr_ptr <= bump(wr_ptr);
            if (pop)  rd_ptr <= bump(rd_ptr);
            case ({push, pop})
                2'b10:   fill <= fill + CW'(1);
                2'b01:   fill <= fill - CW'(1);
                default: fill <= fill;
            endcase
        end
    end
endmodule

// File: rtl/ifq_issue.sv
module ifq_issue
    import ifq_pkg::*;
#(
    parameter int WORD_W = 32,
    parameter int DEPTH  = 2,
    localparam int CW    = cnt_w(DEPTH),
    localparam int HALF_W = WORD_W / 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              flush,
    input  issue_mode_e       mode,
    input  logic [CW-1:0]     fill,
    input  logic [WORD_W-1:0] head_word,
    input  logic              dec_ready,
    input  logic              dec_stall,
    output logic              dec_valid,
    output logic [WORD_W-1:0] dec_instr,
    output logic              dec_upper,
    output logic              pop
);
    unpack_state_t st_q;
    unpack_state_t st_d;
    logic          have_head;
    logic          take;

    assign have_head = (fill != '0);

    always_comb begin
        if (mode == ISSUE_HALF) begin
            dec_valid = have_head && st_q.armed;
            dec_upper = st_q.lower_done;
            dec_instr = {{HALF_W{1'b0}},
                         st_q.lower_done ? head_word[WORD_W-1:HALF_W]
                                         : head_word[HALF_W-1:0]};
        end else begin
            dec_valid = have_head;
            dec_upper = 1'b0;
            dec_instr = head_word;
        end
    end

    assign take = dec_valid && dec_ready && !dec_stall;
    assign pop  = take && (mode == ISSUE_WORD || st_q.lower_done);

    // armed: the word that will be at the head next cycle is already held now
    always_comb begin
        st_d.armed      = pop ? (fill > CW'(1)) : have_head;
        st_d.lower_done = (mode == ISSUE_HALF && take) ? !st_q.lower_done
                                                       : st_q.lower_done;
    end

    always_ff @(posedge clk) begin
        if (rst || flush) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end
endmodule

// File: rtl/ifetch_queue.sv
module ifetch_queue
    import ifq_pkg::*;
#(
    parameter int WORD_W = 32,
    parameter int DEPTH  = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              compact,
    input  logic              flush,
    input  logic              fetch_valid,
    input  logic [WORD_W-1:0] fetch_word,
    output logic              fetch_ready,
    input  logic              dec_ready,
    input  logic              dec_stall,
    output logic              dec_valid,
    output logic [WORD_W-1:0] dec_instr,
    output logic              dec_upper
);
    localparam int CW = cnt_w(DEPTH);

    logic              push;
    logic              pop;
    logic [CW-1:0]     fill;
    logic [WORD_W-1:0] head_word;
    issue_mode_e       mode;

    assign mode        = compact ? ISSUE_HALF : ISSUE_WORD;
    assign fetch_ready = (fill < CW'(DEPTH)) || pop;
    assign push        = fetch_valid && fetch_ready && !flush;

    ifq_store #(.WORD_W(WORD_W), .DEPTH(DEPTH)) u_store (
        .clk       (clk),
        .rst       (rst),
        .flush     (flush),
        .push      (push),
        .wr_word   (fetch_word),
        .pop       (pop),
        .head_word (head_word),
        .fill      (fill)
    );

    ifq_issue #(.WORD_W(WORD_W), .DEPTH(DEPTH)) u_issue (
        .clk       (clk),
        .rst       (rst),
        .flush     (flush),
        .mode      (mode),
        .fill      (fill),
        .head_word (head_word),
        .dec_ready (dec_ready),
        .dec_stall (dec_stall),
        .dec_valid (dec_valid),
        .dec_instr (dec_instr),
        .dec_upper (dec_upper),
        .pop       (pop)
    );
endmodule

// File: rtl/ifq_checks.sv
module ifq_checks #(
    parameter int WORD_W = 32,
    parameter int DEPTH  = 2
) (
    input logic              clk,
    input logic              rst,
    input logic              compact,
    input logic              flush,
    input logic              fetch_valid,
    input logic              fetch_ready,
    input logic              dec_ready,
    input logic              dec_stall,
    input logic              dec_valid,
    input logic [WORD_W-1:0] dec_instr,
    input logic              dec_upper
);
    logic [7:0] occ;
    logic       push_w;
    logic       take_w;
    logic       pop_w;

    assign push_w = fetch_valid && fetch_ready && !flush;
    assign take_w = dec_valid && dec_ready && !dec_stall;
    assign pop_w  = take_w && (!compact || dec_upper);

    always_ff @(posedge clk) begin
        if (rst || flush)          occ <= '0;
        else if (push_w && !pop_w) occ <= occ + 8'd1;
        else if (pop_w && !push_w) occ <= occ - 8'd1;
    end

    // R1
    reset_idle_chk: assert property (@(posedge clk)
        rst |=> !dec_valid && fetch_ready);

    // R5
    occ_bound_chk: assert property (@(posedge clk) disable iff (rst)
        occ <= 8'(DEPTH));

    // R5
    ready_low_chk: assert property (@(posedge clk) disable iff (rst)
        !fetch_ready |-> (occ == 8'(DEPTH)) && !pop_w);

    // R2
    word_latency_chk: assert property (@(posedge clk) disable iff (rst)
        !compact && push_w && occ == 8'd0 |=> compact || dec_valid);

    // R4
    arm_delay_chk: assert property (@(posedge clk) disable iff (rst)
        compact && push_w && occ == 8'd0 |=> !dec_valid);

    // R3
    half_order_chk: assert property (@(posedge clk) disable iff (rst)
        compact && take_w && !dec_upper && !flush |=> !compact || (dec_valid && dec_upper));

    // R6
    stall_hold_chk: assert property (@(posedge clk) disable iff (rst)
        dec_valid && !take_w && !flush |=>
            (compact != $past(compact)) || (dec_valid && $stable(dec_instr) && $stable(dec_upper)));

    // R9
    flush_clear_chk: assert property (@(posedge clk) disable iff (rst)
        flush |=> !dec_valid);
endmodule

bind ifetch_queue ifq_checks #(.WORD_W(WORD_W), .DEPTH(DEPTH)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .compact     (compact),
    .flush       (flush),
    .fetch_valid (fetch_valid),
    .fetch_ready (fetch_ready),
    .dec_ready   (dec_ready),
    .dec_stall   (dec_stall),
    .dec_valid   (dec_valid),
    .dec_instr   (dec_instr),
    .dec_upper   (dec_upper)
);

// File: tb/ifetch_queue_test.sv
module ifetch_queue_test;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        compact = 1'b0;
    logic        flush = 1'b0;
    logic        fetch_valid = 1'b0;
    logic [31:0] fetch_word = '0;
    logic        fetch_ready;
    logic        dec_ready = 1'b0;
    logic        dec_stall = 1'b0;
    logic        dec_valid;
    logic [31:0] dec_instr;
    logic        dec_upper;

    int checks = 0;
    int fails  = 0;

    always #2 clk = ~clk;

    ifetch_queue uut (
        .clk(clk), .rst(rst), .compact(compact), .flush(flush),
        .fetch_valid(fetch_valid), .fetch_word(fetch_word), .fetch_ready(fetch_ready),
        .dec_ready(dec_ready), .dec_stall(dec_stall),
        .dec_valid(dec_valid), .dec_instr(dec_instr), .dec_upper(dec_upper)
    );

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    function automatic logic [31:0] half_pair(input int k);
        return {16'(16'h4000 + 2 * k + 1), 16'(16'h4000 + 2 * k)};
    endfunction

    task automatic run(input bit m, input int fp, input int dp, input int nw);
        int sent = 0;
        int got = 0;
        int occ = 0;
        int cyc = 0;
        int total;
        bit started = 0;
        bit pop_e;
        logic [31:0] ex;
        total = m ? 2 * nw : nw;
        compact = m; flush = 1'b1; fetch_valid = 1'b0; dec_ready = 1'b0; dec_stall = 1'b0;
        tick();
        flush = 1'b0;
        while (got < total && cyc < 400) begin
            fetch_valid = (cyc % fp == 0) && (sent < nw);
            fetch_word  = m ? half_pair(sent) : 32'h9E3779B9 * (sent + 1);
            dec_ready   = (cyc % dp == 0);
            dec_stall   = (fp != 1 || dp != 1) && (cyc % 5 == 4);
            #1;
            pop_e = dec_valid && dec_ready && !dec_stall && (!m || dec_upper);
            // R5 R7 R8: ready only withheld when full with no removal
            chk(fetch_ready == (occ < 2 || pop_e), "R5 fetch_ready", 32'(fetch_ready), 32'(occ < 2 || pop_e));
            if (fp == 1 && dp == 1 && started)
                chk(dec_valid, "R10 no bubble", 32'(dec_valid), 32'd1);
            if (dec_valid && dec_ready && !dec_stall) begin
                if (m) begin
                    ex = 32'h4000 + 32'(got);
                    chk(dec_instr == ex, "R3 halfword order", dec_instr, ex);
                    chk(dec_upper == got[0], "R3 upper flag", 32'(dec_upper), 32'(got[0]));
                end else begin
                    ex = 32'h9E3779B9 * (got + 1);
                    chk(dec_instr == ex, "R2 word order", dec_instr, ex);
                end
                got++;
                started = 1;
            end
            if (fetch_valid && fetch_ready) begin sent++; occ++; end
            if (pop_e) occ--;
            @(posedge clk);
            #1;
            cyc++;
        end
        chk(got == total, "R2 stream complete", 32'(got), 32'(total));
        fetch_valid = 1'b0; dec_ready = 1'b0; dec_stall = 1'b0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        repeat (2) @(posedge clk);
        #1 rst = 1'b0;
        #1;
        chk(dec_valid == 1'b0, "R1 valid after reset", 32'(dec_valid), 32'd0);
        chk(fetch_ready == 1'b1, "R1 ready after reset", 32'(fetch_ready), 32'd1);

        // R2 latency in word mode
        @(posedge clk); #1;
        fetch_valid = 1'b1; fetch_word = 32'hCAFE0001;
        tick();
        fetch_valid = 1'b0; #1;
        chk(dec_valid == 1'b1, "R2 one-cycle latency", 32'(dec_valid), 32'd1);
        chk(dec_instr == 32'hCAFE0001, "R2 head word", dec_instr, 32'hCAFE0001);

        // R6 stall with ready high, fill to two
        dec_ready = 1'b1; dec_stall = 1'b1;
        fetch_valid = 1'b1; fetch_word = 32'hCAFE0002; #1;
        chk(fetch_ready == 1'b1, "R5 room for second", 32'(fetch_ready), 32'd1);
        tick();
        fetch_word = 32'hCAFE0003; #1;
        chk(fetch_ready == 1'b0, "R5 full blocks fetch", 32'(fetch_ready), 32'd0);
        chk(dec_instr == 32'hCAFE0001, "R6 stall holds", dec_instr, 32'hCAFE0001);
        tick();
        #1;
        chk(dec_valid && dec_instr == 32'hCAFE0001, "R6 still held", dec_instr, 32'hCAFE0001);

        // R7 push and pop in the same cycle while full
        dec_stall = 1'b0; #1;
        chk(fetch_ready == 1'b1, "R7 full with pop accepts", 32'(fetch_ready), 32'd1);
        tick();
        fetch_valid = 1'b0; dec_stall = 1'b1; #1;
        chk(dec_instr == 32'hCAFE0002, "R7 next head", dec_instr, 32'hCAFE0002);
        chk(fetch_ready == 1'b0, "R7 occupancy unchanged", 32'(fetch_ready), 32'd0);
        dec_stall = 1'b0;
        tick();
        #1;
        chk(dec_instr == 32'hCAFE0003, "R2 fifo order", dec_instr, 32'hCAFE0003);
        tick();
        #1;
        chk(dec_valid == 1'b0, "R2 drained", 32'(dec_valid), 32'd0);

        // R9 flush beats a push, word mode
        dec_stall = 1'b1;
        fetch_valid = 1'b1; fetch_word = 32'hBEEF0001;
        tick();
        flush = 1'b1; fetch_word = 32'hBEEF0002;
        tick();
        flush = 1'b0; fetch_valid = 1'b0; #1;
        chk(dec_valid == 1'b0, "R9 flush empties", 32'(dec_valid), 32'd0);
        tick();
        #1;
        chk(dec_valid == 1'b0, "R9 flushed push dropped", 32'(dec_valid), 32'd0);

        // R4 extra step in compact mode
        flush = 1'b1; compact = 1'b1; dec_stall = 1'b0;
        tick();
        flush = 1'b0;
        fetch_valid = 1'b1; fetch_word = 32'h2222_1111;
        tick();
        fetch_valid = 1'b0; #1;
        chk(dec_valid == 1'b0, "R4 not yet shown", 32'(dec_valid), 32'd0);
        tick();
        #1;
        chk(dec_valid && !dec_upper && dec_instr == 32'h1111, "R3 lower first", dec_instr, 32'h1111);
        tick();
        #1;
        chk(dec_valid && dec_upper && dec_instr == 32'h2222, "R3 upper second", dec_instr, 32'h2222);
        tick();
        #1;
        chk(dec_valid == 1'b0, "R3 word consumed", 32'(dec_valid), 32'd0);

        // R8 lower half taken from a full queue does not free an entry
        dec_stall = 1'b1;
        fetch_valid = 1'b1; fetch_word = half_pair(0);
        tick();
        fetch_word = half_pair(1);
        tick();
        fetch_word = half_pair(2); dec_stall = 1'b0; #1;
        chk(fetch_ready == 1'b0, "R8 lower take keeps full", 32'(fetch_ready), 32'd0);
        tick();
        #1;
        chk(fetch_ready == 1'b1, "R8 upper take frees", 32'(fetch_ready), 32'd1);
        tick();
        fetch_valid = 1'b0;
        for (int j = 2; j < 6; j++) begin
            #1;
            chk(dec_valid && dec_instr == 32'h4000 + 32'(j), "R8 order after full", dec_instr, 32'h4000 + 32'(j));
            tick();
        end

        // R9 flush after a lower half was taken
        dec_stall = 1'b1;
        fetch_valid = 1'b1; fetch_word = 32'h7777_6666;
        tick();
        fetch_valid = 1'b0;
        tick();
        dec_stall = 1'b0;
        tick();
        #1;
        chk(dec_upper == 1'b1, "R3 upper pending", 32'(dec_upper), 32'd1);
        flush = 1'b1; dec_stall = 1'b1;
        tick();
        flush = 1'b0; fetch_valid = 1'b1; fetch_word = 32'h9999_8888;
        tick();
        fetch_valid = 1'b0;
        tick();
        #1;
        chk(dec_valid && !dec_upper && dec_instr == 32'h8888, "R9 half state forgotten", dec_instr, 32'h8888);

        // sweep of fetch and decode rates in both modes
        for (int m = 0; m < 2; m++)
            for (int fp = 1; fp <= 3; fp++)
                for (int dp = 1; dp <= 3; dp++)
                    run(m[0], fp, dp, 6);

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule